// File: doc/BRIEF.md
# Chained Vector Execution Unit

This block executes integer vector instructions against an internal file of eight vector registers, each holding sixteen 16-bit elements. An instruction selects an operation (add, multiply or divide), two source registers and a destination register. Each operation has its own functional unit. Once an instruction is accepted, the unit for that operation reads one element pair per cycle, pushes it into a fixed-latency pipeline, and writes one result per cycle when the pipeline drains. How many elements are processed is set by a length register, and a per-element mask decides which results are stored. Both values are captured when the instruction is accepted.

The three units run concurrently. A hazard tracker holds one outstanding-write bit for each element of each register. This lets a dependent instruction on another unit start reading the elements of its source as each one is written, without waiting for the producer to finish (chaining). The issue handshake refuses an instruction whose unit is still reading elements, whose destination still has writes outstanding, or whose destination is a source of a unit that is still reading. A host port loads and reads elements directly. A host port also writes the length and mask registers.

Top module: `vpu_core`

## Requirements
- R1: After reset the length register reads 16, the mask is all ones, every element of every register reads 0, `unit_busy` and `unit_done` are 0, and `iss_ready` is 1 for a valid operation.
- R2: A length write of a value above 16 stores 16. Any other value, 0 included, is stored as written and reads back on `vl_q` from the next cycle.
- R3: `iss_op` 0 is add, which wraps modulo 2^16. `iss_op` 1 is multiply, which keeps the low 16 bits. `iss_op` 2 is unsigned divide, which gives quotient 0xFFFF when the divisor is 0. `iss_op` 3 is never accepted and changes nothing.
- R4: Add and multiply have a startup latency of 6 cycles and divide has 20. With no chaining stall, element 0 is written on the LAT-th edge after the accept edge. The unit's `unit_done` bit is high for exactly one cycle, in the cycle after the edge that writes the last element, which is LAT+VL-1 edges after acceptance.
- R5: Elements 0 to VL-1 are produced one per cycle in index order. Elements at index VL and above in the destination are left unchanged.
- R6: Mask bit i (bit 0 is element 0) set to 0 leaves destination element i unchanged. Mask and length are sampled at the accept edge, and later writes to them do not affect an accepted instruction.
- R7: `unit_busy` bit u (0 add, 1 mul, 2 div) is high for VL cycles starting the cycle after acceptance. While it is high, `iss_ready` is 0 for operation u.
- R8: Chaining: a dependent instruction reads element i of a source in the cycle after the producing instruction writes that element. For an add followed one cycle later by a multiply that reads the add's result, the multiply's done comes 11+VL edges after the add's accept edge.
- R9: `iss_ready` is 0 when the destination has any outstanding element write, or when the destination is a source of a unit that is still busy. A source with outstanding writes does not block issue.
- R10: With length 0 an instruction is accepted, writes nothing, never raises busy, and pulses its done bit in the cycle after acceptance.
- R11: Two units that write back in the same cycle both store their results, and both done bits rise in that cycle.
- R12: An instruction whose destination is also a source reads each element's old value before overwriting it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vl_we | input | 1 | Write enable for the length register |
| vl_wdata | input | 8 | New length, clamped to 16 |
| vl_q | output | 5 | Current length register |
| mask_we | input | 1 | Write enable for the mask register |
| mask_wdata | input | 16 | New mask, bit i gates element i |
| host_we | input | 1 | Host element write enable |
| host_wreg | input | 3 | Host write register number |
| host_widx | input | 4 | Host write element index |
| host_wdata | input | 16 | Host write data |
| host_rreg | input | 3 | Host read register number |
| host_ridx | input | 4 | Host read element index |
| host_rdata | output | 16 | Host read data (combinational) |
| iss_valid | input | 1 | Instruction presented |
| iss_op | input | 2 | Operation code |
| iss_vd | input | 3 | Destination register |
| iss_vs1 | input | 3 | First source register |
| iss_vs2 | input | 3 | Second source register |
| iss_ready | output | 1 | Instruction can be accepted this cycle |
| unit_busy | output | 3 | Per-unit element reading in progress |
| unit_done | output | 3 | Per-unit last element retired |

## Verification
Two of this block's functions can fall in the same cycle: the add and multiply units can each write back a result, and each raise its done bit. The test provokes this by accepting a length-5 add, rewriting the length to 3 on the next edge, and accepting a multiply on the edge after that. The two last elements then retire on the same edge. The monitor compares each done pulse against the cycle its queued entry predicts, and the register contents of both destinations are then checked against the reference model. The same monitor checks the chained multiply, whose done cycle reflects the stall that waits on the producer's writebacks.

// File: rtl/vpu_pkg.sv
package vpu_pkg;

    localparam int DATA_W    = 16;
    localparam int MAX_VL    = 16;
    localparam int NUM_VREG  = 8;
    localparam int NUM_UNIT  = 3;
    localparam int VLIN_W    = 8;
    localparam int IDX_W     = $clog2(MAX_VL);
    localparam int REG_W     = $clog2(NUM_VREG);
    localparam int LEN_W     = $clog2(MAX_VL + 1);

    typedef logic [DATA_W-1:0] elem_t;

    typedef enum logic [1:0] {
        OP_ADD  = 2'd0,
        OP_MUL  = 2'd1,
        OP_DIV  = 2'd2,
        OP_NONE = 2'd3
    } vop_e;

    // One element travelling through a functional-unit pipeline
    typedef struct packed {
        logic             valid;
        logic             we;
        logic             last;
        logic [REG_W-1:0] vreg;
        logic [IDX_W-1:0] idx;
        elem_t            data;
    } velem_t;

    function automatic elem_t op_eval(vop_e op, elem_t a, elem_t b);
        logic [2*DATA_W-1:0] prod;
        prod = (2*DATA_W)'(a) * (2*DATA_W)'(b);
        case (op)
            OP_ADD:  return a + b;
            OP_MUL:  return prod[DATA_W-1:0];
            OP_DIV:  return (b == '0) ? '1 : (a / b);
            default: return '0;
        endcase
    endfunction

    function automatic logic [LEN_W-1:0] clamp_len(logic [VLIN_W-1:0] v);
        if (v > VLIN_W'(MAX_VL))
            return LEN_W'(MAX_VL);
        return v[LEN_W-1:0];
    endfunction

endpackage

// File: rtl/vpu_vrf.sv
module vpu_vrf
    import vpu_pkg::*;
#(
    parameter int NWR = NUM_UNIT,
    parameter int NRD = 2 * NUM_UNIT + 1
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      host_we,
    input  logic [REG_W-1:0]          host_reg,
    input  logic [IDX_W-1:0]          host_idx,
    input  elem_t                     host_data,
    input  logic [NWR-1:0]            wr_en,
    input  logic [NWR-1:0][REG_W-1:0] wr_reg,
    input  logic [NWR-1:0][IDX_W-1:0] wr_idx,
    input  elem_t [NWR-1:0]           wr_data,
    input  logic [NRD-1:0][REG_W-1:0] rd_reg,
    input  logic [NRD-1:0][IDX_W-1:0] rd_idx,
    output elem_t [NRD-1:0]           rd_data
);

    elem_t mem [NUM_VREG][MAX_VL];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int r = 0; r < NUM_VREG; r++)
                for (int i = 0; i < MAX_VL; i++)
                    mem[r][i] <= '0;
        end else begin
            if (host_we)
                mem[host_reg][host_idx] <= host_data;
            for (int p = 0; p < NWR; p++)
                if (wr_en[p])
                    mem[wr_reg[p]][wr_idx[p]] <= wr_data[p];
        end
    end

    always_comb begin
        for (int p = 0; p < NRD; p++)
            rd_data[p] = mem[rd_reg[p]][rd_idx[p]];
    end

endmodule

// File: rtl/vpu_pending.sv
module vpu_pending
    import vpu_pkg::*;
#(
    parameter int NCLR = NUM_UNIT
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              set_en,
    input  logic [REG_W-1:0]                  set_reg,
    input  logic [LEN_W-1:0]                  set_len,
    input  logic [NCLR-1:0]                   clr_en,
    input  logic [NCLR-1:0][REG_W-1:0]        clr_reg,
    input  logic [NCLR-1:0][IDX_W-1:0]        clr_idx,
    output logic [NUM_VREG-1:0][MAX_VL-1:0]   pend
);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= '0;
        end else begin
            for (int p = 0; p < NCLR; p++)
                if (clr_en[p])
                    pend[clr_reg[p]][clr_idx[p]] <= 1'b0;
            for (int r = 0; r < NUM_VREG; r++)
                for (int i = 0; i < MAX_VL; i++)
                    if (set_en && set_reg == REG_W'(r) && LEN_W'(i) < set_len)
                        pend[r][i] <= 1'b1;
        end
    end

endmodule

// File: rtl/vpu_unit.sv
module vpu_unit
    import vpu_pkg::*;
#(
    parameter vop_e OP  = OP_ADD,
    parameter int   LAT = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [REG_W-1:0]  start_vd,
    input  logic [REG_W-1:0]  start_vs1,
    input  logic [REG_W-1:0]  start_vs2,
    input  logic [LEN_W-1:0]  start_len,
    input  logic [MAX_VL-1:0] start_mask,
    input  logic              src_ok,
    input  elem_t             opnd_a,
    input  elem_t             opnd_b,
    output logic              busy,
    output logic [REG_W-1:0]  rd_vs1,
    output logic [REG_W-1:0]  rd_vs2,
    output logic [REG_W-1:0]  cur_vd,
    output logic [IDX_W-1:0]  rd_idx,
    output logic              wb_valid,
    output logic              wb_we,
    output logic [REG_W-1:0]  wb_reg,
    output logic [IDX_W-1:0]  wb_idx,
    output elem_t             wb_data,
    output logic              done
);

    localparam int DEPTH = LAT - 1;

    logic              act_q;
    logic [REG_W-1:0]  vd_q, vs1_q, vs2_q;
    logic [LEN_W-1:0]  len_q;
    logic [MAX_VL-1:0] mask_q;
    logic [IDX_W-1:0]  idx_q;
    logic              done_q;
    logic              step;
    logic              last_el;
    velem_t            entry;
    velem_t            stage [DEPTH];

    assign step    = act_q && src_ok;
    assign last_el = (LEN_W'(idx_q) + LEN_W'(1)) == len_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q  <= 1'b0;
            vd_q   <= '0;
            vs1_q  <= '0;
            vs2_q  <= '0;
            len_q  <= '0;
            mask_q <= '0;
            idx_q  <= '0;
        end else if (start && start_len != '0) begin
            act_q  <= 1'b1;
            vd_q   <= start_vd;
            vs1_q  <= start_vs1;
            vs2_q  <= start_vs2;
            len_q  <= start_len;
            mask_q <= start_mask;
            idx_q  <= '0;
        end else if (step) begin
            idx_q <= idx_q + IDX_W'(1);
            if (last_el)
                act_q <= 1'b0;
        end
    end

    always_comb begin
        entry.valid = step;
        entry.we    = mask_q[idx_q];
        entry.last  = last_el;
        entry.vreg  = vd_q;
        entry.idx   = idx_q;
        entry.data  = op_eval(OP, opnd_a, opnd_b);
    end

    genvar k;
    generate
        for (k = 0; k < DEPTH; k++) begin : g_stage
            if (k == 0) begin : g_head
                always_ff @(posedge clk) begin
                    if (rst) stage[0] <= '0;
                    else     stage[0] <= entry;
                end
            end else begin : g_body
                always_ff @(posedge clk) begin
                    if (rst) stage[k] <= '0;
                    else     stage[k] <= stage[k-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) done_q <= 1'b0;
        else     done_q <= (stage[DEPTH-1].valid && stage[DEPTH-1].last) ||
                           (start && start_len == '0);
    end

    assign busy     = act_q;
    assign rd_vs1   = vs1_q;
    assign rd_vs2   = vs2_q;
    assign cur_vd   = vd_q;
    assign rd_idx   = idx_q;
    assign wb_valid = stage[DEPTH-1].valid;
    assign wb_we    = stage[DEPTH-1].valid && stage[DEPTH-1].we;
    assign wb_reg   = stage[DEPTH-1].vreg;
    assign wb_idx   = stage[DEPTH-1].idx;
    assign wb_data  = stage[DEPTH-1].data;
    assign done     = done_q;

endmodule

// File: rtl/vpu_core.sv
module vpu_core
    import vpu_pkg::*;
#(
    parameter int LAT_ADD = 6,
    parameter int LAT_MUL = 6,
    parameter int LAT_DIV = 20
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                vl_we,
    input  logic [VLIN_W-1:0]   vl_wdata,
    output logic [LEN_W-1:0]    vl_q,
    input  logic                mask_we,
    input  logic [MAX_VL-1:0]   mask_wdata,
    input  logic                host_we,
    input  logic [REG_W-1:0]    host_wreg,
    input  logic [IDX_W-1:0]    host_widx,
    input  logic [DATA_W-1:0]   host_wdata,
    input  logic [REG_W-1:0]    host_rreg,
    input  logic [IDX_W-1:0]    host_ridx,
    output logic [DATA_W-1:0]   host_rdata,
    input  logic                iss_valid,
    input  logic [1:0]          iss_op,
    input  logic [REG_W-1:0]    iss_vd,
    input  logic [REG_W-1:0]    iss_vs1,
    input  logic [REG_W-1:0]    iss_vs2,
    output logic                iss_ready,
    output logic [NUM_UNIT-1:0] unit_busy,
    output logic [NUM_UNIT-1:0] unit_done
);

    localparam int NRD = 2 * NUM_UNIT + 1;

    logic [LEN_W-1:0]  len_q;
    logic [MAX_VL-1:0] mask_q;

    logic [NUM_UNIT-1:0]              busy, src_ok, done;
    logic [NUM_UNIT-1:0][REG_W-1:0]   u_vs1, u_vs2, u_vd;
    logic [NUM_UNIT-1:0][IDX_W-1:0]   u_idx;
    logic [NUM_UNIT-1:0]              wb_valid, wb_we;
    logic [NUM_UNIT-1:0][REG_W-1:0]   wb_reg;
    logic [NUM_UNIT-1:0][IDX_W-1:0]   wb_idx;
    elem_t [NUM_UNIT-1:0]             wb_data;

    logic [NRD-1:0][REG_W-1:0]        rd_reg;
    logic [NRD-1:0][IDX_W-1:0]        rd_idx;
    elem_t [NRD-1:0]                  rd_data;
    logic [NUM_VREG-1:0][MAX_VL-1:0]  pend;

    logic op_ok, sel_busy, waw, war, fire;

    // Length and mask registers
    always_ff @(posedge clk) begin
        if (rst) begin
            len_q  <= LEN_W'(MAX_VL);
            mask_q <= '1;
        end else begin
            if (vl_we)   len_q  <= clamp_len(vl_wdata);
            if (mask_we) mask_q <= mask_wdata;
        end
    end

    // Issue hazard check
    always_comb begin
        op_ok    = iss_op != OP_NONE;
        sel_busy = 1'b0;
        war      = 1'b0;
        for (int u = 0; u < NUM_UNIT; u++) begin
            if (iss_op == 2'(u) && busy[u])
                sel_busy = 1'b1;
            if (busy[u] && (u_vs1[u] == iss_vd || u_vs2[u] == iss_vd))
                war = 1'b1;
        end
        waw       = |pend[iss_vd];
        iss_ready = op_ok && !sel_busy && !waw && !war;
        fire      = iss_valid && iss_ready;
    end

    genvar u;
    generate
        for (u = 0; u < NUM_UNIT; u++) begin : g_unit
            localparam int L = (u == 0) ? LAT_ADD : (u == 1) ? LAT_MUL : LAT_DIV;

            // chaining: wait on source elements still owed by another unit
            assign src_ok[u] =
                !(u_vs1[u] != u_vd[u] && pend[u_vs1[u]][u_idx[u]]) &&
                !(u_vs2[u] != u_vd[u] && pend[u_vs2[u]][u_idx[u]]);

            assign rd_reg[2*u]   = u_vs1[u];
            assign rd_reg[2*u+1] = u_vs2[u];
            assign rd_idx[2*u]   = u_idx[u];
            assign rd_idx[2*u+1] = u_idx[u];

            vpu_unit #(.OP(vop_e'(u)), .LAT(L)) u_fu (
                .clk        (clk),
                .rst        (rst),
                .start      (fire && iss_op == 2'(u)),
                .start_vd   (iss_vd),
                .start_vs1  (iss_vs1),
                .start_vs2  (iss_vs2),
                .start_len  (len_q),
                .start_mask (mask_q),
                .src_ok     (src_ok[u]),
                .opnd_a     (rd_data[2*u]),
                .opnd_b     (rd_data[2*u+1]),
                .busy       (busy[u]),
                .rd_vs1     (u_vs1[u]),
                .rd_vs2     (u_vs2[u]),
                .cur_vd     (u_vd[u]),
                .rd_idx     (u_idx[u]),
                .wb_valid   (wb_valid[u]),
                .wb_we      (wb_we[u]),
                .wb_reg     (wb_reg[u]),
                .wb_idx     (wb_idx[u]),
                .wb_data    (wb_data[u]),
                .done       (done[u])
            );
        end
    endgenerate

    assign rd_reg[NRD-1] = host_rreg;
    assign rd_idx[NRD-1] = host_ridx;

    vpu_vrf #(.NWR(NUM_UNIT), .NRD(NRD)) u_vrf (
        .clk       (clk),
        .rst       (rst),
        .host_we   (host_we),
        .host_reg  (host_wreg),
        .host_idx  (host_widx),
        .host_data (host_wdata),
        .wr_en     (wb_we),
        .wr_reg    (wb_reg),
        .wr_idx    (wb_idx),
        .wr_data   (wb_data),
        .rd_reg    (rd_reg),
        .rd_idx    (rd_idx),
        .rd_data   (rd_data)
    );

    vpu_pending #(.NCLR(NUM_UNIT)) u_pend (
        .clk     (clk),
        .rst     (rst),
        .set_en  (fire),
        .set_reg (iss_vd),
        .set_len (len_q),
        .clr_en  (wb_valid),
        .clr_reg (wb_reg),
        .clr_idx (wb_idx),
        .pend    (pend)
    );

    assign vl_q       = len_q;
    assign host_rdata = rd_data[NRD-1];
    assign unit_busy  = busy;
    assign unit_done  = done;

endmodule

// File: rtl/vpu_core_chk.sv
module vpu_core_chk
    import vpu_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                iss_valid,
    input logic                iss_ready,
    input logic [1:0]          iss_op,
    input logic [LEN_W-1:0]    vl_q,
    input logic [NUM_UNIT-1:0] unit_busy,
    input logic [NUM_UNIT-1:0] unit_done
);

    // R2
    vl_cap_chk: assert property (@(posedge clk) disable iff (rst)
        vl_q <= LEN_W'(MAX_VL));

    // R3
    bad_op_chk: assert property (@(posedge clk) disable iff (rst)
        (iss_valid && iss_op == 2'd3) |-> !iss_ready);

    genvar u;
    generate
        for (u = 0; u < NUM_UNIT; u++) begin : g_chk
            // R7
            busy_block_chk: assert property (@(posedge clk) disable iff (rst)
                unit_busy[u] |-> !(iss_valid && iss_ready && iss_op == 2'(u)));

            // R7
            busy_start_chk: assert property (@(posedge clk) disable iff (rst)
                $rose(unit_busy[u]) |-> $past(iss_valid && iss_ready && iss_op == 2'(u)));

            // R10
            zero_len_chk: assert property (@(posedge clk) disable iff (rst)
                (iss_valid && iss_ready && iss_op == 2'(u) && vl_q == '0)
                |=> (unit_done[u] && !unit_busy[u]));
        end
    endgenerate

endmodule

bind vpu_core vpu_core_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .iss_valid (iss_valid),
    .iss_ready (iss_ready),
    .iss_op    (iss_op),
    .vl_q      (vl_q),
    .unit_busy (unit_busy),
    .unit_done (unit_done)
);

// File: tb/vpu_core_tb.sv
module vpu_core_tb;
    import vpu_pkg::*;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst;
    logic        vl_we;
    logic [7:0]  vl_wdata;
    logic [4:0]  vl_q;
    logic        mask_we;
    logic [15:0] mask_wdata;
    logic        host_we;
    logic [2:0]  host_wreg, host_rreg;
    logic [3:0]  host_widx, host_ridx;
    logic [15:0] host_wdata, host_rdata;
    logic        iss_valid, iss_ready;
    logic [1:0]  iss_op;
    logic [2:0]  iss_vd, iss_vs1, iss_vs2;
    logic [2:0]  unit_busy, unit_done;

    vpu_core u_dut (
        .clk(clk), .rst(rst), .vl_we(vl_we), .vl_wdata(vl_wdata), .vl_q(vl_q),
        .mask_we(mask_we), .mask_wdata(mask_wdata), .host_we(host_we),
        .host_wreg(host_wreg), .host_widx(host_widx), .host_wdata(host_wdata),
        .host_rreg(host_rreg), .host_ridx(host_ridx), .host_rdata(host_rdata),
        .iss_valid(iss_valid), .iss_op(iss_op), .iss_vd(iss_vd),
        .iss_vs1(iss_vs1), .iss_vs2(iss_vs2), .iss_ready(iss_ready),
        .unit_busy(unit_busy), .unit_done(unit_done)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int nchk = 0;
    int nfail = 0;
    logic [15:0] refm [8][16];
    int          sh_vl = 16;
    logic [15:0] sh_mask = 16'hFFFF;
    int q0[$];
    int q1[$];
    int q2[$];

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    endtask

    function automatic logic [15:0] ref_op(input int op, input logic [15:0] a, input logic [15:0] b);
        logic [31:0] p;
        p = {16'h0, a} * {16'h0, b};
        if (op == 0) return a + b;
        if (op == 1) return p[15:0];
        return (b == 16'h0) ? 16'hFFFF : a / b;
    endfunction

    function automatic int lat_of(input int op);
        return (op == 2) ? 20 : 6;
    endfunction

    // scoreboard monitor: each done pulse pops its predicted cycle
    always @(negedge clk) begin
        if (!rst) begin
            for (int u = 0; u < 3; u++) begin
                if (unit_done[u]) begin
                    int e;
                    int n;
                    e = -1;
                    n = (u == 0) ? q0.size() : (u == 1) ? q1.size() : q2.size();
                    if (n > 0) begin
                        if (u == 0) e = q0.pop_front();
                        else if (u == 1) e = q1.pop_front();
                        else e = q2.pop_front();
                    end
                    check(e == cyc, "R4", $sformatf("done cycle unit %0d", u), cyc, e);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        summary();
    end

    task automatic host_write(input int r, input int i, input logic [15:0] d);
        @(negedge clk);
        host_we = 1'b1; host_wreg = 3'(r); host_widx = 4'(i); host_wdata = d;
        @(posedge clk); #1;
        host_we = 1'b0;
        refm[r][i] = d;
    endtask

    task automatic set_vl(input int v);
        @(negedge clk);
        vl_we = 1'b1; vl_wdata = 8'(v);
        @(posedge clk); #1;
        vl_we = 1'b0;
        sh_vl = (v > 16) ? 16 : v;
    endtask

    task automatic set_mask(input logic [15:0] m);
        @(negedge clk);
        mask_we = 1'b1; mask_wdata = m;
        @(posedge clk); #1;
        mask_we = 1'b0;
        sh_mask = m;
    endtask

    task automatic issue(input int op, input int vd, input int s1, input int s2,
                         input int extra, input string req);
        int c0;
        int ex;
        @(negedge clk);
        iss_valid = 1'b1; iss_op = 2'(op);
        iss_vd = 3'(vd); iss_vs1 = 3'(s1); iss_vs2 = 3'(s2);
        #1;
        check(iss_ready == 1'b1, req, "issue accepted", int'(iss_ready), 1);
        @(posedge clk); #1;
        iss_valid = 1'b0;
        c0 = cyc;
        ex = (sh_vl == 0) ? c0 : c0 + lat_of(op) + sh_vl - 1 + extra;
        if (op == 0) q0.push_back(ex);
        else if (op == 1) q1.push_back(ex);
        else q2.push_back(ex);
        for (int i = 0; i < sh_vl; i++)
            if (sh_mask[i])
                refm[vd][i] = ref_op(op, refm[s1][i], refm[s2][i]);
    endtask

    task automatic chk_reg(input int r, input string req);
        int bad;
        int act;
        int exp;
        bad = 0; act = 0; exp = 0;
        for (int i = 0; i < 16; i++) begin
            host_rreg = 3'(r); host_ridx = 4'(i);
            #1;
            if (host_rdata !== refm[r][i] && bad == 0) begin
                bad = 1; act = int'(host_rdata); exp = int'(refm[r][i]);
                $display("  v%0d[%0d] mismatch", r, i);
            end
        end
        check(bad == 0, req, $sformatf("register v%0d contents", r), act, exp);
    endtask

    task automatic settle();
        repeat (45) @(posedge clk);
        #1;
    endtask

    initial begin
        rst = 1'b1;
        vl_we = 0; vl_wdata = 0; mask_we = 0; mask_wdata = 0;
        host_we = 0; host_wreg = 0; host_widx = 0; host_wdata = 0;
        host_rreg = 0; host_ridx = 0;
        iss_valid = 0; iss_op = 0; iss_vd = 0; iss_vs1 = 0; iss_vs2 = 0;
        for (int r = 0; r < 8; r++)
            for (int i = 0; i < 16; i++)
                refm[r][i] = 16'h0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check(vl_q == 5'd16, "R1", "reset length", int'(vl_q), 16);
        check(unit_busy == 3'b0, "R1", "reset busy", int'(unit_busy), 0);
        check(unit_done == 3'b0, "R1", "reset done", int'(unit_done), 0);
        iss_op = 2'd0; iss_vd = 3'd3; #1;
        check(iss_ready == 1'b1, "R1", "reset ready", int'(iss_ready), 1);
        chk_reg(0, "R1");
        chk_reg(7, "R1");

        // operands: wrapping values and zero divisors
        for (int i = 0; i < 16; i++) begin
            host_write(1, i, 16'hF000 + 16'(i) * 16'h0123);
            host_write(2, i, (i % 4 == 0) ? 16'h0 : 16'(i) * 16'h0101 + 16'd3);
            host_write(4, i, 16'hA5A5);
        end

        // R3 R4 R5 full-length add with default mask
        issue(0, 3, 1, 2, 0, "R4");
        settle();
        chk_reg(3, "R3");

        // R2 clamp
        set_vl(40);
        @(negedge clk);
        check(vl_q == 5'd16, "R2", "clamped length", int'(vl_q), 16);
        set_vl(5);
        @(negedge clk);
        check(vl_q == 5'd5, "R2", "written length", int'(vl_q), 5);

        // R6 R5 masked multiply, mask changed right after issue
        set_mask(16'b1011_0110_1011_0110);
        issue(1, 4, 1, 2, 0, "R6");
        set_mask(16'hFFFF);
        settle();
        chk_reg(4, "R6");

        // R3 divide (zero divisor), R9 hazards while it runs
        set_vl(16);
        issue(2, 5, 1, 2, 0, "R3");
        @(negedge clk);
        iss_op = 2'd0; iss_vd = 3'd5; iss_vs1 = 3'd1; iss_vs2 = 3'd2; #1;
        check(iss_ready == 1'b0, "R9", "write-after-write blocked", int'(iss_ready), 0);
        iss_op = 2'd1; iss_vd = 3'd1; #1;
        check(iss_ready == 1'b0, "R9", "write-after-read blocked", int'(iss_ready), 0);
        iss_vd = 3'd6; iss_vs1 = 3'd5; #1;
        check(iss_ready == 1'b1, "R9", "pending source allowed", int'(iss_ready), 1);
        settle();
        chk_reg(5, "R3");

        // R7 busy window
        set_vl(4);
        issue(0, 6, 2, 2, 0, "R7");
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            check(unit_busy[0] == (k < 4), "R7", $sformatf("add busy at +%0d", k),
                  int'(unit_busy[0]), (k < 4) ? 1 : 0);
            if (k == 0 || k == 4) begin
                iss_op = 2'd0; iss_vd = 3'd7; iss_vs1 = 3'd1; iss_vs2 = 3'd2; #1;
                check(iss_ready == (k == 4), "R7", "ready for busy unit",
                      int'(iss_ready), (k == 4) ? 1 : 0);
            end
        end
        settle();
        chk_reg(6, "R7");

        // R8 chaining: mul consumes add result element by element
        set_vl(8);
        issue(0, 3, 5, 2, 0, "R8");
        issue(1, 7, 3, 1, 5, "R8");
        settle();
        chk_reg(3, "R8");
        chk_reg(7, "R8");

        // R12 destination equals source
        issue(0, 1, 1, 2, 0, "R12");
        settle();
        chk_reg(1, "R12");

        // R11 two units retire in the same cycle
        set_vl(5);
        issue(0, 3, 2, 4, 0, "R11");
        set_vl(3);
        issue(1, 6, 4, 5, 0, "R11");
        settle();
        chk_reg(3, "R11");
        chk_reg(6, "R11");

        // R10 zero length
        set_vl(0);
        issue(2, 2, 1, 1, 0, "R10");
        @(negedge clk);
        check(unit_busy == 3'b0, "R10", "no busy at length 0", int'(unit_busy), 0);
        settle();
        chk_reg(2, "R10");

        // R3 reserved opcode never accepted, no effect
        set_vl(4);
        @(negedge clk);
        iss_valid = 1'b1; iss_op = 2'd3; iss_vd = 3'd0; iss_vs1 = 3'd1; iss_vs2 = 3'd2; #1;
        check(iss_ready == 1'b0, "R3", "reserved op refused", int'(iss_ready), 0);
        @(posedge clk); #1;
        iss_valid = 1'b0;
        settle();
        chk_reg(0, "R3");

        for (int r = 0; r < 8; r++)
            chk_reg(r, "R5");
        check(q0.size() + q1.size() + q2.size() == 0, "R4", "missing done pulses",
              q0.size() + q1.size() + q2.size(), 0);
        summary();
    end

endmodule